// File: doc/BRIEF.md
# Settling Emulator for a Two-Variable Asynchronous Machine

This block is a clocked stand-in for a clockless feedback circuit. The circuit has one input and two feedback variables. A fast clock drives it. On each edge the block forms the excitation of the network from its present state and a held copy of the input. When the excitation differs from the state, the block copies the excitation into the state register. It keeps doing this, one update per edge, until the excitation matches the state. The pair of state and input is then a stable total state. At that point the block raises its rest flag and reports how many updates the settling took.

The held input is refreshed from the pin only while the machine is at rest. An input change that arrives during settling waits until the network has come to rest. This gives the single-input-change discipline of fundamental-mode operation.

Some networks never come to rest. If the state has not settled after a bounded number of updates, a sticky oscillation flag is raised and stays set until reset. The network is chosen by a parameter:
- Network 0 is the two-variable machine described below.
- Network 1 is a ring network. It exists to exercise the oscillation path.

Top module: `async_settle_emu`

Control phases:
- REST: the network is at rest and the input is sampled.
- SETTLE: updates are being applied.
- LOCK: oscillation has been detected.

Phase transitions:
- REST→REST when the network is at rest.
- REST→SETTLE when the excitation differs from the state; one update is applied.
- SETTLE→REST when the network is at rest; the step count is captured.
- SETTLE→SETTLE when the network is not at rest and the bound is not reached; one more update is applied.
- SETTLE→LOCK when the network is still not at rest after `MAX_STEPS` updates.
- LOCK→LOCK until reset.

## Requirements
- R1: A synchronous active-high `rst` sets `y_state` to 00 and the held input to 0. It clears `oscillating` and sets `settle_steps` to 0. After reset `stable` reads 1.
- R2: With `NET_SEL`=0, `y_state` is {y1,y2} with y1 in bit 1. The excitation is Y1 = x·y1 + x'·y2 and Y2 = x·y1' + x'·y2. Driving x = 1, 0, 1, 0 from state 00 walks the state through 01, 11, 10 and 00.
- R3: `stable` is 1 exactly when the excitation equals `y_state`. For network 0 the stable total states y1y2x are 000, 011, 110 and 101.
- R4: Whenever `stable` is 0, the next edge loads the excitation into `y_state`, so exactly one update is made per clock. A new input value is sampled on one edge and changes the state on the following edge.
- R5: `x_in` is sampled only on an edge in REST while `stable` is 1. An input change made while settling is held until the first such edge after the network comes to rest.
- R6: On the edge where settling completes, `settle_steps` is loaded with the number of updates made. It never exceeds `MAX_STEPS` and does not change while `stable` is 0.
- R7: If `stable` is still 0 after `MAX_STEPS` updates, the next update edge sets `oscillating`. It then stays 1 until reset. While it is set, `x_in` is ignored and updates continue.
- R8: With `NET_SEL`=1, x=0 holds every state. With x=1 the state steps 00→10→11→01→00 and never rests.
- R9: While `stable` is 1, `y_state` does not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast emulation clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Input of the emulated network |
| y_state | output | 2 | Present feedback state {y1,y2} |
| stable | output | 1 | Excitation equals state (stable total state) |
| oscillating | output | 1 | Sticky flag: no rest within the step bound |
| settle_steps | output | $clog2(MAX_STEPS+1) | Updates taken by the last completed settling |

## Verification
The properties assume `rst` is held high for at least one edge before checking starts. They also assume `x_in` is a clean synchronous level. The rule that only one input changes while the network is at rest needs no promise from the stimulus, because the block enforces it by holding the input. The bench drives `x_in` on falling edges. It normally waits for rest before the next change. In one scenario it deliberately changes the input mid-settling, so the holding behaviour is actually exercised rather than assumed.

// File: rtl/ase_pkg.sv
package ase_pkg;

    typedef enum logic [1:0] {
        PH_REST   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_LOCK   = 2'd2
    } ase_phase_e;

    localparam int STATE_W = 2;

    typedef logic [STATE_W-1:0] ase_vec_t;

endpackage

// File: rtl/ase_excite_net.sv
module ase_excite_net
    import ase_pkg::*;
#(
    parameter int NET_SEL = 0
) (
    input  ase_vec_t cur,
    input  logic     x,
    output ase_vec_t nxt
);

    // cur[1] is y1, cur[0] is y2
    generate
        if (NET_SEL == 0) begin : g_table_net
            always_comb begin
                nxt[1] = x ? cur[1]  : cur[0];
                nxt[0] = x ? ~cur[1] : cur[0];
            end
        end else begin : g_ring_net
            // x=1 rotates through a four-state ring, x=0 holds
            always_comb begin
                nxt[1] = x ? ~cur[0] : cur[1];
                nxt[0] = x ? cur[1]  : cur[0];
            end
        end
    endgenerate

endmodule

// File: rtl/ase_step_counter.sv
module ase_step_counter #(
    parameter int MAX_STEPS = 4,
    localparam int CW = $clog2(MAX_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          inc,
    input  logic          capture,
    output logic          limit_hit,
    output logic [CW-1:0] steps_out
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] steps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            steps_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (inc) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (capture) begin
            steps_q <= cnt_q;
            cnt_q   <= '0;
        end
    end

    assign limit_hit = (cnt_q == CW'(MAX_STEPS));
    assign steps_out = steps_q;

endmodule

// File: rtl/ase_phase_fsm.sv
module ase_phase_fsm
    import ase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       settled,
    input  logic       limit_hit,
    output logic       sample_en,
    output logic       update_en,
    output logic       cnt_start,
    output logic       cnt_inc,
    output logic       cnt_capture,
    output logic       lock_flag
);

    ase_phase_e phase_q;
    ase_phase_e phase_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_REST;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_REST:   phase_d = settled ? PH_REST : PH_SETTLE;
            PH_SETTLE: begin
                if (settled) begin
                    phase_d = PH_REST;
                end else if (limit_hit) begin
                    phase_d = PH_LOCK;
                end else begin
                    phase_d = PH_SETTLE;
                end
            end
            PH_LOCK:   phase_d = PH_LOCK;
            default:   phase_d = PH_REST;
        endcase
    end

    always_comb begin
        sample_en   = 1'b0;
        update_en   = 1'b0;
        cnt_start   = 1'b0;
        cnt_inc     = 1'b0;
        cnt_capture = 1'b0;
        lock_flag   = 1'b0;
        unique case (phase_q)
            PH_REST: begin
                sample_en = settled;
                update_en = !settled;
                cnt_start = !settled;
            end
            PH_SETTLE: begin
                update_en   = !settled;
                cnt_inc     = !settled && !limit_hit;
                cnt_capture = settled;
            end
            PH_LOCK: begin
                update_en = !settled;
                lock_flag = 1'b1;
            end
            default: begin
                sample_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/async_settle_emu.sv
module async_settle_emu
    import ase_pkg::*;
#(
    parameter int MAX_STEPS = 4,
    parameter int NET_SEL   = 0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             x_in,
    output logic [1:0]                       y_state,
    output logic                             stable,
    output logic                             oscillating,
    output logic [$clog2(MAX_STEPS+1)-1:0]   settle_steps
);

    ase_vec_t state_q;
    ase_vec_t excite;
    logic     x_held;
    logic     settled;
    logic     sample_en;
    logic     update_en;
    logic     cnt_start;
    logic     cnt_inc;
    logic     cnt_capture;
    logic     limit_hit;

    ase_excite_net #(.NET_SEL(NET_SEL)) u_net (
        .cur (state_q),
        .x   (x_held),
        .nxt (excite)
    );

    assign settled = (excite == state_q);

    ase_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .settled     (settled),
        .limit_hit   (limit_hit),
        .sample_en   (sample_en),
        .update_en   (update_en),
        .cnt_start   (cnt_start),
        .cnt_inc     (cnt_inc),
        .cnt_capture (cnt_capture),
        .lock_flag   (oscillating)
    );

    ase_step_counter #(.MAX_STEPS(MAX_STEPS)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start     (cnt_start),
        .inc       (cnt_inc),
        .capture   (cnt_capture),
        .limit_hit (limit_hit),
        .steps_out (settle_steps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            x_held  <= 1'b0;
        end else begin
            if (update_en) begin
                state_q <= excite;
            end
            if (sample_en) begin
                x_held <= x_in;
            end
        end
    end

    assign y_state = state_q;
    assign stable  = settled;

endmodule

// File: rtl/ase_checker.sv
module ase_checker #(
    parameter int MAX_STEPS = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     y_state,
    input logic                           stable,
    input logic                           oscillating,
    input logic [$clog2(MAX_STEPS+1)-1:0] settle_steps
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (y_state == 2'b00 && !oscillating && settle_steps == '0));

    // R9
    hold_when_stable_chk: assert property (@(posedge clk) disable iff (rst)
        stable |=> $stable(y_state));

    // R4
    step_when_unstable_chk: assert property (@(posedge clk) disable iff (rst)
        !stable |=> (y_state != $past(y_state)));

    // R7
    osc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        oscillating |=> oscillating);

    // R7
    osc_needs_unrest_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oscillating) |-> !$past(stable));

    // R6
    steps_bound_chk: assert property (@(posedge clk) disable iff (rst)
        settle_steps <= ($clog2(MAX_STEPS+1))'(MAX_STEPS));

    // R6
    steps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !stable |=> $stable(settle_steps));

endmodule

bind async_settle_emu ase_checker #(.MAX_STEPS(MAX_STEPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .y_state      (y_state),
    .stable       (stable),
    .oscillating  (oscillating),
    .settle_steps (settle_steps)
);

// File: tb/async_settle_emu_bench.sv
module async_settle_emu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x_a = 1'b0;
    logic       x_b = 1'b0;
    logic [1:0] y_a, y_b;
    logic       st_a, st_b, osc_a, osc_b;
    logic [2:0] steps_a, steps_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    async_settle_emu #(.MAX_STEPS(4), .NET_SEL(0)) u_async_settle_emu (
        .clk(clk), .rst(rst), .x_in(x_a), .y_state(y_a), .stable(st_a),
        .oscillating(osc_a), .settle_steps(steps_a)
    );

    async_settle_emu #(.MAX_STEPS(4), .NET_SEL(1)) u_async_settle_emu_ring (
        .clk(clk), .rst(rst), .x_in(x_b), .y_state(y_b), .stable(st_b),
        .oscillating(osc_b), .settle_steps(steps_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        x_a = 1'b0;
        x_b = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", int'(y_a), 0);
        check("R1 stable", int'(st_a), 1);
        check("R1 osc", int'(osc_a), 0);
        check("R1 steps", int'(steps_a), 0);
    endtask

    task automatic apply(input logic xv, input int exp_state);
        x_a = xv;
        tick();
        check("R3 unstable after sample", int'(st_a), 0);
        tick();
        check("R2 next state", int'(y_a), exp_state);
        check("R3 rest reached", int'(st_a), 1);
        tick();
        check("R6 steps", int'(steps_a), 1);
    endtask

    task automatic t_walk();
        do_reset();
        apply(1'b1, 1);
        apply(1'b0, 3);
        apply(1'b1, 2);
        apply(1'b0, 0);
    endtask

    task automatic t_idle();
        // R9: no input change leaves the rest state untouched
        repeat (3) tick();
        check("R9 state held", int'(y_a), 0);
        check("R9 stable held", int'(st_a), 1);
        check("R6 steps kept", int'(steps_a), 1);
    endtask

    task automatic t_hold();
        do_reset();
        x_a = 1'b1;
        tick();
        x_a = 1'b0;
        tick();
        check("R5 state after first input", int'(y_a), 1);
        check("R5 change held", int'(st_a), 1);
        tick();
        check("R5 still held", int'(st_a), 1);
        tick();
        check("R5 sampled at rest", int'(st_a), 0);
        tick();
        check("R5 late change applied", int'(y_a), 3);
    endtask

    task automatic t_osc();
        do_reset();
        check("R8 ring holds x0", int'(st_b), 1);
        x_b = 1'b1;
        tick();
        tick();
        check("R8 ring step1", int'(y_b), 2);
        tick();
        check("R8 ring step2", int'(y_b), 3);
        tick();
        check("R8 ring step3", int'(y_b), 1);
        tick();
        check("R8 ring step4", int'(y_b), 0);
        check("R7 no osc yet", int'(osc_b), 0);
        tick();
        check("R7 osc set", int'(osc_b), 1);
        check("R7 update continues", int'(y_b), 2);
        x_b = 1'b0;
        tick();
        check("R7 input ignored", int'(y_b), 3);
        repeat (5) tick();
        check("R7 osc sticky", int'(osc_b), 1);
        check("R7 not stable", int'(st_b), 0);
        check("R1 default net never oscillates", int'(osc_a), 0);
        do_reset();
        check("R1 osc cleared", int'(osc_b), 0);
        check("R1 ring state", int'(y_b), 0);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_walk();
        t_idle();
        t_hold();
        t_osc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule